// File: doc/BRIEF.md
# Double-Buffered 10-bit PWM Generator

This block generates one pulse-width-modulated output from a free-running 10-bit counter. The counter advances on ticks from a prescaler that divides the system clock by 1, 2 or 8. Software programs the block through a byte-wide write port. A 10-bit period and a 10-bit duty value are each assembled from a low byte and a two-bit field in a shared high register. A control byte holds the run bit, the output enable, the polarity and the clock select.

The duty value is double-buffered. A write lands in a master register. The compare logic uses a separate slave copy, which takes the master value only at the tick where the counter reaches the period. A duty change made partway through a cycle therefore takes effect at the start of the next cycle, and the current pulse is never cut short or stretched. A duty of zero forces a steady inactive level. A duty equal to the period forces a steady active level. In both cases the polarity bit picks the actual pin level.

The write port has no back-pressure: every write strobe is accepted in the cycle it is presented, so the port carries no ready signal. Writes take effect on the next clock edge.

Top module: `pwm10_gen`

## Requirements
- R1: The period is {high register bits [3:2], period low byte}. The period low byte is written at address 1 and the high register at address 3.
- R2: The master duty is {high register bits [1:0], duty low byte}. The duty low byte is written at address 2.
- R3: Control byte fields at address 0 are: bit 0 run, bit 1 output enable, bit 2 polarity, bits [5:4] clock select. Select 00 gives a tick every clock, 01 every 2 clocks, and 10 or 11 every 8 clocks.
- R4: While running, the counter returns to 0 on the tick where it equals the period, so a cycle lasts (period+1) ticks. For 0 < duty < period, the output is active while counter <= slave duty, which is (duty+1) ticks, and inactive for (period-duty) ticks.
- R5: The slave duty takes the master value only on a wrap tick. A duty write in the middle of a cycle leaves that cycle's timing unchanged and applies from the next cycle.
- R6: Polarity 1 makes the active level high. Polarity 0 makes the active level low.
- R7: A slave duty equal to the period (and nonzero) holds the pin at the active level for the whole cycle.
- R8: A slave duty of zero holds the pin at the inactive level: low for polarity 1, high for polarity 0.
- R9: With output enable 0, the pin drives the inactive level (the inverse of polarity) whatever the counter does.
- R10: With run 0, the counter and the prescaler hold at 0 and the slave duty follows the master, so starting uses the latest duty at once.
- R11: After reset, all registers are zero and the pin is high (disabled, inactive level for polarity 0).
- R12: Changing only the period while running keeps the active time at (duty+1) ticks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe, accepted every cycle |
| wr_addr | input | 2 | Register address (0 control, 1 period low, 2 duty low, 3 high bits) |
| wr_data | input | 8 | Register write data |
| pwm_out | output | 1 | PWM pin level |

## Verification
The hardest case to reach from the ports is a duty write that arrives while the active phase is still in progress, before the slave copy has moved. The bench aligns itself on an observed edge into the active level and issues the write within the same active window. It then measures that cycle and the following cycle separately. The extremes are reached by programming duty equal to the period and duty zero under each polarity. After each change, the bench waits past one wrap so that the slave holds the new value before it watches the steady level.

// File: rtl/pwm10_pkg.sv
package pwm10_pkg;
  localparam int PWM_W   = 10;
  localparam int BYTE_W  = 8;
  localparam int ADDR_W  = 2;
  localparam int SEL_W   = 2;
  localparam int PDIV_W  = 3;

  typedef struct packed {
    logic [SEL_W-1:0] csel;
    logic             pol;
    logic             oe;
    logic             run;
  } pwm_cfg_t;

  localparam logic [ADDR_W-1:0] A_CTRL  = 2'd0;
  localparam logic [ADDR_W-1:0] A_PLO   = 2'd1;
  localparam logic [ADDR_W-1:0] A_DLO   = 2'd2;
  localparam logic [ADDR_W-1:0] A_HIGH  = 2'd3;
endpackage

// File: rtl/pwm10_regs.sv
module pwm10_regs
  import pwm10_pkg::*;
#(
  parameter int W  = PWM_W,
  parameter int DW = BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DW-1:0]     wr_data,
  output pwm_cfg_t          cfg,
  output logic [W-1:0]      period,
  output logic [W-1:0]      duty_m
);
  localparam int HW = W - DW;

  logic [DW-1:0]   per_lo_q, duty_lo_q;
  logic [2*HW-1:0] hi_q;
  pwm_cfg_t        cfg_q;
  logic            unused_bits;

  assign unused_bits = ^{wr_data[DW-1:6], wr_data[3]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q     <= '0;
      per_lo_q  <= '0;
      duty_lo_q <= '0;
      hi_q      <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        A_CTRL: begin
          cfg_q.run  <= wr_data[0];
          cfg_q.oe   <= wr_data[1];
          cfg_q.pol  <= wr_data[2];
          cfg_q.csel <= wr_data[5:4];
        end
        A_PLO:   per_lo_q  <= wr_data;
        A_DLO:   duty_lo_q <= wr_data;
        default: hi_q      <= wr_data[2*HW-1:0];
      endcase
    end
  end

  assign cfg    = cfg_q;
  assign period = {hi_q[2*HW-1:HW], per_lo_q};
  assign duty_m = {hi_q[HW-1:0], duty_lo_q};
endmodule

// File: rtl/pwm10_prescale.sv
module pwm10_prescale
  import pwm10_pkg::*;
#(
  parameter int CW = PDIV_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [SEL_W-1:0] csel,
  output logic             tick
);
  logic [CW-1:0] pcnt_q;
  logic [CW-1:0] last;

  always_comb begin
    case (csel)
      2'b00:   last = CW'(0);
      2'b01:   last = CW'(1);
      default: last = CW'(7);
    endcase
  end

  assign tick = run && (pcnt_q >= last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pcnt_q <= '0;
    else if (!run)    pcnt_q <= '0;
    else if (tick)    pcnt_q <= '0;
    else              pcnt_q <= pcnt_q + 1'b1;
  end
endmodule

// File: rtl/pwm10_core.sv
module pwm10_core
  import pwm10_pkg::*;
#(
  parameter int W = PWM_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         tick,
  input  logic         oe,
  input  logic         pol,
  input  logic [W-1:0] period,
  input  logic [W-1:0] duty_m,
  output logic [W-1:0] cnt,
  output logic [W-1:0] slave,
  output logic         pwm_out
);
  logic [W-1:0] cnt_q, slave_q;
  logic         wrap, active;

  assign wrap = tick && (cnt_q == period);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      slave_q <= '0;
    end else if (!run) begin
      cnt_q   <= '0;
      slave_q <= duty_m;
    end else if (wrap) begin
      cnt_q   <= '0;
      slave_q <= duty_m;
    end else if (tick) begin
      cnt_q   <= cnt_q + 1'b1;
    end
  end

  assign active  = (slave_q != '0) && (cnt_q <= slave_q);
  assign pwm_out = oe ? ~(active ^ pol) : ~pol;
  assign cnt     = cnt_q;
  assign slave   = slave_q;
endmodule

// File: rtl/pwm10_gen.sv
module pwm10_gen
  import pwm10_pkg::*;
#(
  parameter int W = PWM_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  output logic              pwm_out
);
  pwm_cfg_t     cfg_q;
  logic [W-1:0] period, duty_m, cnt, slave;
  logic         tick;

  pwm10_regs #(.W(W), .DW(BYTE_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .cfg(cfg_q), .period(period), .duty_m(duty_m)
  );

  pwm10_prescale #(.CW(PDIV_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .run(cfg_q.run), .csel(cfg_q.csel), .tick(tick)
  );

  pwm10_core #(.W(W)) u_core (
    .clk(clk), .rst_n(rst_n), .run(cfg_q.run), .tick(tick), .oe(cfg_q.oe),
    .pol(cfg_q.pol), .period(period), .duty_m(duty_m), .cnt(cnt),
    .slave(slave), .pwm_out(pwm_out)
  );
endmodule

// File: rtl/pwm10_chk.sv
module pwm10_chk #(
  parameter int W = 10
) (
  input logic         clk,
  input logic         rst_n,
  input logic         run,
  input logic         oe,
  input logic         pol,
  input logic         tick,
  input logic [W-1:0] period,
  input logic [W-1:0] cnt,
  input logic [W-1:0] slave,
  input logic         pwm_out
);
  assert_stop_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt == '0));

  assert_wrap_to_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (run && tick && cnt == period) |=> (cnt == '0));

  assert_slave_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !(tick && cnt == period)) |=> (slave == $past(slave)));

  assert_disabled_level_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !oe |-> (pwm_out == !pol));

  assert_zero_duty_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (oe && slave == '0) |-> (pwm_out == !pol));

  assert_full_duty_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (oe && slave != '0 && slave >= period && cnt <= period) |-> (pwm_out == pol));
endmodule

bind pwm10_gen pwm10_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .run(cfg_q.run), .oe(cfg_q.oe), .pol(cfg_q.pol),
  .tick(tick), .period(period), .cnt(cnt), .slave(slave), .pwm_out(pwm_out)
);

// File: tb/pwm10_gen_test.sv
module pwm10_gen_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       pwm_out;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  pwm10_gen uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .pwm_out(pwm_out)
  );

  always #10 clk = ~clk;

  // Behavioural reference model, advanced on every rising edge
  int m_run, m_oe, m_pol, m_csel, m_plo, m_dlo, m_hi;
  int m_pcnt, m_cnt, m_slave;

  always @(posedge clk) begin
    int per, dm, lastp;
    bit tk;
    if (!rst_n) begin
      m_run = 0; m_oe = 0; m_pol = 0; m_csel = 0;
      m_plo = 0; m_dlo = 0; m_hi = 0;
      m_pcnt = 0; m_cnt = 0; m_slave = 0;
    end else begin
      per   = (((m_hi >> 2) & 3) << 8) | m_plo;
      dm    = ((m_hi & 3) << 8) | m_dlo;
      lastp = (m_csel == 0) ? 0 : (m_csel == 1) ? 1 : 7;
      if (m_run == 0) begin
        m_pcnt = 0; m_cnt = 0; m_slave = dm;
      end else begin
        tk = (m_pcnt >= lastp);
        m_pcnt = tk ? 0 : m_pcnt + 1;
        if (tk) begin
          if (m_cnt == per) begin m_cnt = 0; m_slave = dm; end
          else m_cnt = (m_cnt + 1) % 1024;
        end
      end
      if (wr_en) begin
        case (wr_addr)
          2'd0: begin
            m_run = wr_data[0]; m_oe = wr_data[1];
            m_pol = wr_data[2]; m_csel = wr_data[5:4];
          end
          2'd1: m_plo = wr_data;
          2'd2: m_dlo = wr_data;
          default: m_hi = wr_data[3:0];
        endcase
      end
    end
  end

  function automatic bit model_out();
    bit act;
    act = (m_slave != 0) && (m_cnt <= m_slave);
    if (m_oe == 0) return !m_pol;
    return m_pol ? act : !act;
  endfunction

  // Every-clock comparison against the model (R4 R6 R7 R8 R9 R10)
  always @(negedge clk) begin
    if (rst_n && !done) begin
      n_cmp++;
      if (pwm_out !== model_out()) begin
        n_bad++;
        $display("FAIL R4 per-cycle t=%0t actual=%0b expected=%0b", $time, pwm_out, model_out());
      end
    end
  end

  task automatic check(string tag, int got, int exp);
    n_cmp++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, got, exp);
    end
  endtask

  task automatic wr(int a, int d);
    wr_en = 1'b1; wr_addr = 2'(a); wr_data = 8'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic ctrl(int run, int oe, int pol, int csel);
    wr(0, (csel << 4) | (pol << 2) | (oe << 1) | run);
  endtask

  task automatic set_pd(int p, int d);
    wr(1, p & 8'hff);
    wr(2, d & 8'hff);
    wr(3, (((p >> 8) & 3) << 2) | ((d >> 8) & 3));
  endtask

  task automatic sync_active(bit lvl);
    bit prev;
    prev = pwm_out;
    forever begin
      @(negedge clk);
      if (prev != lvl && pwm_out == lvl) break;
      prev = pwm_out;
    end
  endtask

  task automatic count_run(bit lvl, output int n);
    n = 0;
    while (pwm_out == lvl) begin n++; @(negedge clk); end
  endtask

  task automatic measure(string tag, bit lvl, int ehi, int elo);
    int hi, lo;
    sync_active(lvl);
    count_run(lvl, hi);
    count_run(!lvl, lo);
    check({tag, " active"}, hi, ehi);
    check({tag, " inactive"}, lo, elo);
  endtask

  task automatic steady(string tag, bit lvl, int settle, int n);
    int bad;
    bad = 0;
    repeat (settle) @(negedge clk);
    repeat (n) begin
      if (pwm_out != lvl) bad++;
      @(negedge clk);
    end
    check(tag, bad, 0);
  endtask

  task automatic finish_up();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(20 * 150000);
    n_bad++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    int hi, lo;
    repeat (3) @(negedge clk);
    check("R11 reset level", pwm_out, 1);
    rst_n = 1'b1;
    @(negedge clk);
    check("R11 level after reset release", pwm_out, 1);

    // R1 R2 R4: small values, divide by 1
    set_pd(9, 4);
    ctrl(1, 1, 1, 0);
    measure("R4 P9 D4 div1", 1'b1, 5, 5);

    // R3: divide by 2 and by 8
    ctrl(1, 1, 1, 1);
    measure("R3 P9 D4 div2", 1'b1, 10, 10);
    ctrl(0, 1, 1, 2);
    set_pd(9, 2);
    ctrl(1, 1, 1, 2);
    measure("R3 P9 D2 div8", 1'b1, 24, 56);
    ctrl(1, 1, 1, 3);
    measure("R3 P9 D2 sel11", 1'b1, 24, 56);

    // R1 R2: values using the high bits, divide by 2
    ctrl(0, 1, 1, 1);
    set_pd(709, 341);
    ctrl(1, 1, 1, 1);
    measure("R1 R2 P709 D341", 1'b1, 684, 736);

    // R6: polarity 0 makes the active phase low
    ctrl(1, 1, 0, 1);
    measure("R6 pol0 P709 D341", 1'b0, 684, 736);

    // R12: change period only, active time kept
    ctrl(0, 1, 1, 0);
    set_pd(9, 4);
    ctrl(1, 1, 1, 0);
    wr(1, 14);
    sync_active(1'b1);
    measure("R12 P14 D4", 1'b1, 5, 10);

    // R5: mid-cycle duty write
    sync_active(1'b1);
    wr(2, 10);
    count_run(1'b1, hi);
    count_run(1'b0, lo);
    check("R5 cycle of write active", hi + 1, 5);
    check("R5 cycle of write inactive", lo, 10);
    count_run(1'b1, hi);
    count_run(1'b0, lo);
    check("R5 next cycle active", hi, 11);
    check("R5 next cycle inactive", lo, 4);

    // R7: duty equal to period, both polarities
    wr(2, 14);
    steady("R7 full duty pol1", 1'b1, 20, 40);
    ctrl(1, 1, 0, 0);
    steady("R7 full duty pol0", 1'b0, 2, 40);

    // R8: zero duty, both polarities
    wr(2, 0);
    steady("R8 zero duty pol0", 1'b1, 20, 40);
    ctrl(1, 1, 1, 0);
    steady("R8 zero duty pol1", 1'b0, 2, 40);

    // R9: output disabled drives inactive level
    wr(2, 4);
    ctrl(1, 0, 1, 0);
    steady("R9 disabled pol1", 1'b0, 2, 40);
    ctrl(1, 0, 0, 0);
    steady("R9 disabled pol0", 1'b1, 2, 40);

    // R10: stopped counter holds at zero; slave follows master while stopped
    ctrl(0, 1, 1, 0);
    steady("R10 stopped with duty 4", 1'b1, 2, 40);
    wr(2, 0);
    steady("R10 stopped slave follows zero", 1'b0, 2, 20);
    wr(2, 7);
    ctrl(1, 1, 1, 0);
    count_run(1'b1, hi);
    check("R10 first cycle after start active", hi, 8);

    repeat (5) @(negedge clk);
    finish_up();
  end
endmodule